// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block follows a CAN node's standing on the bus, using two error counters: one for transmit errors and one for receive errors. A protocol engine sends it one-cycle strobes when it detects a transmit error or a receive error, and when a frame is sent or received without error. The block moves the counters up and down on these strobes and derives the node's state from them. The state is error-active, error-passive or bus-off. Both counter values and the passive and bus-off flags are available to the rest of the chip at all times.

A node that reaches bus-off stays there until it has seen 128 runs of 11 consecutive recessive bits. The protocol engine reports each sampled bit with a strobe and a level. When the last run completes, the node returns to error-active with both counters at zero. Whenever the passive flag or the bus-off flag changes, the block can raise a one-cycle interrupt, gated by an enable input.

Top module: `can_fault_conf`

## Requirements
- R1: After synchronous reset, both counters are 0, the state is error-active (both flags low) and the interrupt output is low.
- R2: A transmit error strobe adds 8 to the transmit counter and a receive error strobe adds 1 to the receive counter. The receive counter saturates at 255 and never wraps.
- R3: A success strobe lowers its counter by 1, and never below 0. When an error strobe and a success strobe for the same direction arrive in the same cycle, the error strobe takes effect and the success strobe is ignored.
- R4: On the same clock edge that either counter becomes greater than 127, the passive flag goes high (unless the node is in bus-off).
- R5: On the same clock edge that both counters are again 127 or less, the passive flag goes low and the node is error-active.
- R6: On the same clock edge that the transmit counter becomes greater than 255, the bus-off flag goes high and the passive flag goes low.
- R7: While in bus-off, error and success strobes leave both counters unchanged.
- R8: In bus-off, the edge that completes the 128th run of 11 consecutive recessive bits clears the bus-off flag and sets both counters to 0. A bit is counted when the bit strobe is high, and it is recessive when the level input is 1.
- R9: A dominant bit (bit strobe high, level input 0) during recovery restarts the run in progress. Runs already completed are kept.
- R10: When the interrupt enable is high, any change of the passive flag or the bus-off flag gives a one-cycle high pulse on the interrupt output, on the same edge as the flag change. When the enable is low, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_i | input | 1 | Transmit error detected (one-cycle strobe) |
| rx_err_i | input | 1 | Receive error detected (one-cycle strobe) |
| tx_ok_i | input | 1 | Frame transmitted without error (strobe) |
| rx_ok_i | input | 1 | Frame received without error (strobe) |
| bit_stb_i | input | 1 | A bus bit was sampled this cycle |
| bit_rec_i | input | 1 | Level of the sampled bit: 1 is recessive, 0 is dominant |
| irq_en_i | input | 1 | Enables the status-change interrupt |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| passive_o | output | 1 | Node is error-passive |
| busoff_o | output | 1 | Node is bus-off |
| irq_o | output | 1 | One-cycle pulse when a status flag changes |

## Verification
The bench drives the receive counter to exactly 128 and then back to 127. A design with an off-by-one threshold would switch the passive flag one event early or late, and its interrupt pulse would land on the wrong cycle. It drives the transmit counter from 248 to 256, where a counter only 8 bits wide would wrap to zero instead of entering bus-off. It also sends error strobes during bus-off, which a design without the freeze would count. During recovery it inserts a dominant bit into a partial run and then stops one bit short of the 128th run. A design that keeps the partial run leaves bus-off too early. A design that also discards completed runs never leaves bus-off.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;

    typedef struct packed {
        logic tx_err;
        logic rx_err;
        logic tx_ok;
        logic rx_ok;
    } fc_evt_t;

    typedef struct packed {
        logic passive;
        logic busoff;
    } fc_flags_t;

    function automatic fc_flags_t fc_flags_of(input fc_state_e st);
        fc_flags_t f;
        f.passive = (st == FC_PASSIVE);
        f.busoff  = (st == FC_BUSOFF);
        return f;
    endfunction

endpackage

// File: rtl/fc_err_counters.sv
module fc_err_counters
    import fc_pkg::*;
#(
    parameter int TX_W    = 9,
    parameter int RX_W    = 8,
    parameter int TX_STEP = 8,
    parameter int RX_STEP = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  fc_evt_t         evt,
    input  logic            freeze,
    input  logic            clear,
    output logic [TX_W-1:0] tec,
    output logic [RX_W-1:0] rec,
    output logic [TX_W-1:0] tec_nxt,
    output logic [RX_W-1:0] rec_nxt
);

    logic [TX_W:0] tx_sum;
    logic [RX_W:0] rx_sum;

    assign tx_sum = {1'b0, tec} + (TX_W+1)'(TX_STEP);
    assign rx_sum = {1'b0, rec} + (RX_W+1)'(RX_STEP);

    always_comb begin
        tec_nxt = tec;
        rec_nxt = rec;
        if (clear) begin
            tec_nxt = '0;
            rec_nxt = '0;
        end else if (!freeze) begin
            if (evt.tx_err)
                tec_nxt = tx_sum[TX_W] ? '1 : tx_sum[TX_W-1:0];
            else if (evt.tx_ok && tec != '0)
                tec_nxt = tec - 1'b1;

            if (evt.rx_err)
                rec_nxt = rx_sum[RX_W] ? '1 : rx_sum[RX_W-1:0];
            else if (evt.rx_ok && rec != '0)
                rec_nxt = rec - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tec <= '0;
            rec <= '0;
        end else begin
            tec <= tec_nxt;
            rec <= rec_nxt;
        end
    end

endmodule

// File: rtl/fc_recovery.sv
module fc_recovery #(
    parameter int RUN_BITS  = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic bit_stb,
    input  logic bit_rec,
    output logic done
);

    localparam int BW = (RUN_BITS  > 2) ? $clog2(RUN_BITS)  : 1;
    localparam int RW = (RUN_COUNT > 2) ? $clog2(RUN_COUNT) : 1;
    localparam logic [BW-1:0] BIT_LAST = BW'(RUN_BITS - 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(RUN_COUNT - 1);

    logic [BW-1:0] bit_cnt;
    logic [RW-1:0] run_cnt;
    logic          run_end;

    assign run_end = armed && bit_stb && bit_rec && (bit_cnt == BIT_LAST);
    assign done    = run_end && (run_cnt == RUN_LAST);

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            bit_cnt <= '0;
            run_cnt <= '0;
        end else if (bit_stb) begin
            if (!bit_rec) begin
                bit_cnt <= '0;
            end else if (run_end) begin
                bit_cnt <= '0;
                run_cnt <= done ? '0 : run_cnt + 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fc_state_ctrl.sv
module fc_state_ctrl
    import fc_pkg::*;
#(
    parameter int TX_W       = 9,
    parameter int RX_W       = 8,
    parameter int PASS_LIMIT = 128,
    parameter int BOFF_LIMIT = 256
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TX_W-1:0] tec_nxt,
    input  logic [RX_W-1:0] rec_nxt,
    input  logic            recovered,
    input  logic            irq_en,
    output fc_state_e       state,
    output logic            irq
);

    localparam logic [TX_W-1:0] TX_PASS_TH = TX_W'(PASS_LIMIT - 1);
    localparam logic [RX_W-1:0] RX_PASS_TH = RX_W'(PASS_LIMIT - 1);
    localparam logic [TX_W-1:0] TX_BOFF_TH = TX_W'(BOFF_LIMIT - 1);

    fc_state_e state_nxt;
    fc_flags_t cur_f, nxt_f;

    always_comb begin
        state_nxt = state;
        if (state == FC_BUSOFF) begin
            if (recovered)
                state_nxt = FC_ACTIVE;
        end else if (tec_nxt > TX_BOFF_TH) begin
            state_nxt = FC_BUSOFF;
        end else if (tec_nxt > TX_PASS_TH || rec_nxt > RX_PASS_TH) begin
            state_nxt = FC_PASSIVE;
        end else begin
            state_nxt = FC_ACTIVE;
        end
    end

    assign cur_f = fc_flags_of(state);
    assign nxt_f = fc_flags_of(state_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FC_ACTIVE;
            irq   <= 1'b0;
        end else begin
            state <= state_nxt;
            irq   <= irq_en && (cur_f != nxt_f);
        end
    end

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
    import fc_pkg::*;
#(
    parameter int TX_W       = 9,
    parameter int RX_W       = 8,
    parameter int TX_STEP    = 8,
    parameter int RX_STEP    = 1,
    parameter int PASS_LIMIT = 128,
    parameter int BOFF_LIMIT = 256,
    parameter int RUN_BITS   = 11,
    parameter int RUN_COUNT  = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tx_err_i,
    input  logic            rx_err_i,
    input  logic            tx_ok_i,
    input  logic            rx_ok_i,
    input  logic            bit_stb_i,
    input  logic            bit_rec_i,
    input  logic            irq_en_i,
    output logic [TX_W-1:0] tec_o,
    output logic [RX_W-1:0] rec_o,
    output logic            passive_o,
    output logic            busoff_o,
    output logic            irq_o
);

    fc_evt_t         evt;
    fc_state_e       state;
    fc_flags_t       flags;
    logic            recovered;
    logic [TX_W-1:0] tec_nxt;
    logic [RX_W-1:0] rec_nxt;

    assign evt.tx_err = tx_err_i;
    assign evt.rx_err = rx_err_i;
    assign evt.tx_ok  = tx_ok_i;
    assign evt.rx_ok  = rx_ok_i;

    assign flags = fc_flags_of(state);

    fc_err_counters #(
        .TX_W(TX_W), .RX_W(RX_W), .TX_STEP(TX_STEP), .RX_STEP(RX_STEP)
    ) u_cnt (
        .clk(clk), .rst(rst), .evt(evt),
        .freeze(flags.busoff), .clear(recovered),
        .tec(tec_o), .rec(rec_o), .tec_nxt(tec_nxt), .rec_nxt(rec_nxt)
    );

    fc_recovery #(
        .RUN_BITS(RUN_BITS), .RUN_COUNT(RUN_COUNT)
    ) u_rcv (
        .clk(clk), .rst(rst), .armed(flags.busoff),
        .bit_stb(bit_stb_i), .bit_rec(bit_rec_i), .done(recovered)
    );

    fc_state_ctrl #(
        .TX_W(TX_W), .RX_W(RX_W), .PASS_LIMIT(PASS_LIMIT), .BOFF_LIMIT(BOFF_LIMIT)
    ) u_fsm (
        .clk(clk), .rst(rst), .tec_nxt(tec_nxt), .rec_nxt(rec_nxt),
        .recovered(recovered), .irq_en(irq_en_i), .state(state), .irq(irq_o)
    );

    assign passive_o = flags.passive;
    assign busoff_o  = flags.busoff;

endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
    parameter int TX_W       = 9,
    parameter int RX_W       = 8,
    parameter int PASS_LIMIT = 128
) (
    input logic            clk,
    input logic            rst,
    input logic            tx_err_i,
    input logic            rx_err_i,
    input logic            tx_ok_i,
    input logic            irq_en_i,
    input logic [TX_W-1:0] tec_o,
    input logic [RX_W-1:0] rec_o,
    input logic            passive_o,
    input logic            busoff_o,
    input logic            irq_o
);

    // R2
    rx_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_o == '1 && rx_err_i && !busoff_o) |=> (rec_o == '1));

    // R3
    tx_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (tec_o == '0 && tx_ok_i && !tx_err_i && !busoff_o) |=> (tec_o == '0));

    // R4
    passive_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!busoff_o && rec_o > RX_W'(PASS_LIMIT - 1)) |-> passive_o);

    // R6
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        busoff_o |-> !passive_o);

    // R7
    boff_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        busoff_o |=> (tec_o == $past(tec_o) || tec_o == '0));

    // R8
    boff_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busoff_o) |-> (tec_o == '0 && rec_o == '0));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(irq_en_i));

    // R10
    irq_fire_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_en_i) && (passive_o != $past(passive_o) || busoff_o != $past(busoff_o)))
        |-> irq_o);

endmodule

bind can_fault_conf can_fault_conf_chk #(
    .TX_W(TX_W), .RX_W(RX_W), .PASS_LIMIT(PASS_LIMIT)
) u_chk (
    .clk(clk), .rst(rst), .tx_err_i(tx_err_i), .rx_err_i(rx_err_i),
    .tx_ok_i(tx_ok_i), .irq_en_i(irq_en_i), .tec_o(tec_o), .rec_o(rec_o),
    .passive_o(passive_o), .busoff_o(busoff_o), .irq_o(irq_o)
);

// File: tb/can_fault_conf_bench.sv
`timescale 1ns/1ps
module can_fault_conf_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_err_i = 0, rx_err_i = 0, tx_ok_i = 0, rx_ok_i = 0;
    logic       bit_stb_i = 0, bit_rec_i = 0, irq_en_i = 0;
    logic [8:0] tec_o;
    logic [7:0] rec_o;
    logic       passive_o, busoff_o, irq_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    can_fault_conf u_can_fault_conf (
        .clk(clk), .rst(rst), .tx_err_i(tx_err_i), .rx_err_i(rx_err_i),
        .tx_ok_i(tx_ok_i), .rx_ok_i(rx_ok_i), .bit_stb_i(bit_stb_i),
        .bit_rec_i(bit_rec_i), .irq_en_i(irq_en_i), .tec_o(tec_o),
        .rec_o(rec_o), .passive_o(passive_o), .busoff_o(busoff_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle of stimulus, starting and ending at a falling edge
    task automatic step(input logic te, input logic re, input logic tk,
                        input logic rk, input logic bs, input logic br);
        tx_err_i = te; rx_err_i = re; tx_ok_i = tk; rx_ok_i = rk;
        bit_stb_i = bs; bit_rec_i = br;
        @(negedge clk);
        tx_err_i = 0; rx_err_i = 0; tx_ok_i = 0; rx_ok_i = 0;
        bit_stb_i = 0; bit_rec_i = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 tec", tec_o, 0);
        chk("R1 rec", rec_o, 0);
        chk("R1 passive", passive_o, 0);
        chk("R1 busoff", busoff_o, 0);
        chk("R1 irq", irq_o, 0);
    endtask

    task automatic t_incdec();
        do_reset();
        step(1, 0, 0, 0, 0, 0);
        chk("R2 tec +8", tec_o, 8);
        step(0, 1, 0, 0, 0, 0);
        chk("R2 rec +1", rec_o, 1);
        step(0, 0, 1, 0, 0, 0);
        chk("R3 tec -1", tec_o, 7);
        step(0, 0, 0, 1, 0, 0);
        chk("R3 rec -1", rec_o, 0);
        step(0, 0, 0, 1, 0, 0);
        chk("R3 rec floor", rec_o, 0);
        step(1, 0, 1, 0, 0, 0);
        chk("R3 error wins", tec_o, 15);
    endtask

    task automatic t_passive();
        do_reset();
        irq_en_i = 1;
        for (int i = 0; i < 127; i++) step(0, 1, 0, 0, 0, 0);
        chk("R4 still active at 127", passive_o, 0);
        step(0, 1, 0, 0, 0, 0);
        chk("R4 rec 128", rec_o, 128);
        chk("R4 passive", passive_o, 1);
        chk("R10 irq on entry", irq_o, 1);
        step(0, 0, 0, 0, 0, 0);
        chk("R10 irq one cycle", irq_o, 0);
        step(0, 0, 0, 1, 0, 0);
        chk("R5 active again", passive_o, 0);
        chk("R10 irq on exit", irq_o, 1);
        irq_en_i = 0;
    endtask

    task automatic t_rxsat();
        do_reset();
        for (int i = 0; i < 300; i++) step(0, 1, 0, 0, 0, 0);
        chk("R2 rec saturates", rec_o, 255);
    endtask

    task automatic t_busoff();
        do_reset();
        irq_en_i = 0;
        for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0);
        chk("R4 tec 128", tec_o, 128);
        chk("R4 passive by tx", passive_o, 1);
        chk("R10 no irq when disabled", irq_o, 0);
        for (int i = 0; i < 15; i++) step(1, 0, 0, 0, 0, 0);
        chk("R6 not yet at 248", busoff_o, 0);
        step(1, 0, 0, 0, 0, 0);
        chk("R6 tec 256", tec_o, 256);
        chk("R6 busoff", busoff_o, 1);
        chk("R6 passive cleared", passive_o, 0);
        step(1, 1, 0, 0, 0, 0);
        step(0, 0, 1, 1, 0, 0);
        chk("R7 tec frozen", tec_o, 256);
        chk("R7 rec frozen", rec_o, 0);
    endtask

    task automatic t_recover();
        irq_en_i = 1;
        for (int r = 0; r < 5; r++)
            for (int b = 0; b < 11; b++) step(0, 0, 0, 0, 1, 1);
        for (int b = 0; b < 7; b++) step(0, 0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1, 0);
        for (int r = 0; r < 122; r++)
            for (int b = 0; b < 11; b++) step(0, 0, 0, 0, 1, 1);
        for (int b = 0; b < 10; b++) step(0, 0, 0, 0, 1, 1);
        chk("R9 dominant restarted run", busoff_o, 1);
        step(0, 0, 0, 0, 1, 1);
        chk("R8 busoff cleared", busoff_o, 0);
        chk("R8 passive low", passive_o, 0);
        chk("R8 tec zero", tec_o, 0);
        chk("R8 rec zero", rec_o, 0);
        chk("R10 irq on recovery", irq_o, 1);
        irq_en_i = 0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_incdec();
        t_passive();
        t_rxsat();
        t_busoff();
        t_recover();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule